// File: doc/BRIEF.md
# Write Strobe Centering Calibration Controller

This controller centres one byte lane's write strobe inside its valid write-data window by stepping a 6-bit fine delay tap. A pass begins with a `start` pulse. The tap is loaded with an initial value picked by `init_sel`, which tracks the memory clock frequency. The controller then requests tap limits from an external limit-search engine and waits until that engine answers.

With the limits held, it performs two legs. The first leg steps the tap downward from the initial value. The second leg jumps back to the initial value and steps upward. After every tap move it waits a programmable number of settle cycles and then reads a 2-bit sample class from the comparison logic. A class change between two adjacent taps is an edge. Each leg stops at its first edge or at its limit. Up to four edge taps are recorded, one for each side of the rising and the falling windows. The controller then moves the tap to the midpoint of the chosen window and pulses `done`.

The delay lines, the pattern traffic and the limit search are outside the block. One pass handles one byte lane, and the lanes are calibrated one after another.

Top module: `wdqs_center_cal`

## Requirements
- R1: On `start` in idle, the next cycle has `tap` equal to 28 + `init_sel` (an `init_sel` above 6 gives 34) and `lim_req` high.
- R2: `lim_req` stays high until `lim_done` is seen. That cycle's `lim_left` and `lim_right` are captured, and `lim_req` drops on the next edge.
- R3: The down leg decrements `tap` one step per settled read. It stops at the first class change, or when `tap` is at or below the left limit or at 0, so the lowest tap of a pass is the down-leg stop tap.
- R4: The up leg restarts from the initial tap and increments it. It stops at the first class change, or when `tap` is at or above the right limit or at 63, so the highest tap before `done` is the up-leg stop tap.
- R5: The sample classes are 00 unstable, 01 rising window and 10 falling window; 11 counts as unstable. For adjacent taps lo and lo+1, the class at lo+1 becoming 01 records `edge_found[0]` with `rise_lo_tap`=lo+1. The class at lo being 01 records `edge_found[1]` with `rise_hi_tap`=lo. The same rules with 10 set bits 2 and 3, `fall_lo_tap` and `fall_hi_tap`. One transition may set two bits.
- R6: An edge that is not found keeps its flag at 0 and its tap output at 0.
- R7: The final tap is (left + right) >> 1 of the rising window if either rising flag is set, else of the falling window. A missing left edge counts as 0 and a missing right edge counts as 63. With no flag set, the tap returns to the initial value.
- R8: After every tap move the class is read only once the tap has been steady for `settle_cycles` further cycles.
- R9: `done` is high for exactly one cycle, in the same cycle that `tap` first shows the final value. `tap` then holds until the next `start`.
- R10: Reset gives `tap`=0, `done`=0, `lim_req`=0 and all edge flags and edge taps 0.
- R11: `start` clears every edge flag and edge tap before the new pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a pass for one byte lane |
| init_sel | input | 3 | Initial tap select, 28 + value, capped at 34 |
| settle_cycles | input | 4 | Wait after each tap move before reading the class |
| lim_req | output | 1 | Request to the limit-search engine |
| lim_done | input | 1 | Limit search finished; limits valid |
| lim_left | input | 6 | Lowest allowed tap |
| lim_right | input | 6 | Highest allowed tap |
| sample_class | input | 2 | Comparison result at the current tap |
| tap | output | 6 | Fine delay tap value |
| done | output | 1 | One-cycle pass-complete pulse |
| edge_found | output | 4 | Found flags: rise left, rise right, fall left, fall right |
| rise_lo_tap | output | 6 | First tap of the rising window |
| rise_hi_tap | output | 6 | Last tap of the rising window |
| fall_lo_tap | output | 6 | First tap of the falling window |
| fall_hi_tap | output | 6 | Last tap of the falling window |

## Verification
The bench sweeps every initial tap select against a set of window shapes and two settle lengths. The shapes include a rising window next to a falling window, where one step sets two flags: a design that records only one of them, or swaps lo and lo+1, ends on the wrong centre. Other shapes have a right edge beyond the limit, with 63 standing in, and a left edge beyond the limit, with 0 standing in: a design that centres on the stored zero or on the limit lands visibly low. A degenerate shape has the left limit at the start tap, and a case with no window must return to the start tap. The bench models a delay line that reports 11 until the tap has been steady long enough, so a design that reads one cycle early finds false edges.

// File: rtl/wdqs_center_cal.sv
module wdqs_center_cal #(
  parameter int TW   = 6,
  parameter int SW   = 4,
  parameter int BASE = 28,
  parameter int SPAN = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    init_sel,
  input  logic [SW-1:0] settle_cycles,
  output logic          lim_req,
  input  logic          lim_done,
  input  logic [TW-1:0] lim_left,
  input  logic [TW-1:0] lim_right,
  input  logic [1:0]    sample_class,
  output logic [TW-1:0] tap,
  output logic          done,
  output logic [3:0]    edge_found,
  output logic [TW-1:0] rise_lo_tap,
  output logic [TW-1:0] rise_hi_tap,
  output logic [TW-1:0] fall_lo_tap,
  output logic [TW-1:0] fall_hi_tap
);
  localparam logic [TW-1:0] TMAX = {TW{1'b1}};
  localparam logic [1:0] C_RISE = 2'b01;
  localparam logic [1:0] C_FALL = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_LIM, S_SETTLE, S_DOWN, S_UP, S_CENTER} st_t;
  typedef enum logic [1:0] {P_REF, P_DN, P_UP} ph_t;

  st_t           st;
  ph_t           ph;
  logic [SW-1:0] cnt;
  logic [TW-1:0] init_q, lo_lim, hi_lim;
  logic [1:0]    ref_c, prev_c;
  logic [TW-1:0] etap [4];

  logic [TW-1:0] init_tap;
  assign init_tap = (init_sel > 3'(SPAN)) ? TW'(BASE + SPAN) : TW'(BASE) + TW'(init_sel);

  logic [1:0] cur;
  assign cur = (sample_class == 2'b11) ? 2'b00 : sample_class;

  logic [1:0]    a_c, b_c;
  logic [TW-1:0] lo_t;
  logic [3:0]    wr;
  logic          hit;
  always_comb begin
    if (ph == P_UP) begin
      lo_t = tap - 1'b1;
      a_c  = prev_c;
      b_c  = cur;
    end else begin
      lo_t = tap;
      a_c  = cur;
      b_c  = prev_c;
    end
    wr[0] = (b_c == C_RISE) && (a_c != C_RISE);
    wr[1] = (a_c == C_RISE) && (b_c != C_RISE);
    wr[2] = (b_c == C_FALL) && (a_c != C_FALL);
    wr[3] = (a_c == C_FALL) && (b_c != C_FALL);
    hit   = |wr;
  end

  logic          sel_rise;
  logic [TW-1:0] win_lo, win_hi, final_tap;
  logic [TW:0]   win_sum;
  assign sel_rise  = edge_found[0] | edge_found[1];
  assign win_lo    = sel_rise ? etap[0] : etap[2];
  assign win_hi    = sel_rise ? (edge_found[1] ? etap[1] : TMAX)
                              : (edge_found[3] ? etap[3] : TMAX);
  assign win_sum   = {1'b0, win_lo} + {1'b0, win_hi};
  assign final_tap = (|edge_found) ? win_sum[TW:1] : init_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ph         <= P_REF;
      cnt        <= '0;
      tap        <= '0;
      init_q     <= '0;
      lo_lim     <= '0;
      hi_lim     <= '0;
      ref_c      <= '0;
      prev_c     <= '0;
      lim_req    <= 1'b0;
      done       <= 1'b0;
      edge_found <= '0;
      for (int k = 0; k < 4; k++) etap[k] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          tap        <= init_tap;
          init_q     <= init_tap;
          edge_found <= '0;
          for (int k = 0; k < 4; k++) etap[k] <= '0;
          lim_req    <= 1'b1;
          st         <= S_LIM;
        end
        S_LIM: if (lim_done) begin
          lim_req <= 1'b0;
          lo_lim  <= lim_left;
          hi_lim  <= lim_right;
          cnt     <= settle_cycles;
          ph      <= P_REF;
          st      <= S_SETTLE;
        end
        S_SETTLE: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (ph == P_REF) begin
            ref_c  <= cur;
            prev_c <= cur;
            st     <= S_DOWN;
          end else begin
            for (int k = 0; k < 4; k++)
              if (wr[k]) begin
                edge_found[k] <= 1'b1;
                etap[k]       <= ((k % 2) == 0) ? lo_t + 1'b1 : lo_t;
              end
            prev_c <= cur;
            if (ph == P_DN) begin
              if (hit) begin
                tap    <= init_q;
                prev_c <= ref_c;
                st     <= S_UP;
              end else begin
                st <= S_DOWN;
              end
            end else begin
              st <= hit ? S_CENTER : S_UP;
            end
          end
        end
        S_DOWN: begin
          if (tap <= lo_lim || tap == '0) begin
            tap    <= init_q;
            prev_c <= ref_c;
            st     <= S_UP;
          end else begin
            tap <= tap - 1'b1;
            cnt <= settle_cycles;
            ph  <= P_DN;
            st  <= S_SETTLE;
          end
        end
        S_UP: begin
          if (tap >= hi_lim || tap == TMAX) begin
            st <= S_CENTER;
          end else begin
            tap <= tap + 1'b1;
            cnt <= settle_cycles;
            ph  <= P_UP;
            st  <= S_SETTLE;
          end
        end
        S_CENTER: begin
          tap  <= final_tap;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rise_lo_tap = etap[0];
  assign rise_hi_tap = etap[1];
  assign fall_lo_tap = etap[2];
  assign fall_hi_tap = etap[3];
endmodule

// File: rtl/wdqs_center_cal_chk.sv
module wdqs_center_cal_chk #(
  parameter int TW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          lim_req,
  input logic          lim_done,
  input logic          done,
  input logic [TW-1:0] tap,
  input logic [3:0]    edge_found,
  input logic [TW-1:0] rise_lo_tap,
  input logic [TW-1:0] rise_hi_tap,
  input logic [TW-1:0] fall_lo_tap,
  input logic [TW-1:0] fall_hi_tap
);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_tap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (tap == $past(tap)));

  assert_lim_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_req && !lim_done) |=> lim_req);

  assert_flags_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ((edge_found & $past(edge_found)) == $past(edge_found)));

  assert_missing_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_found[0] -> rise_lo_tap == '0) && (!edge_found[1] -> rise_hi_tap == '0) &&
    (!edge_found[2] -> fall_lo_tap == '0) && (!edge_found[3] -> fall_hi_tap == '0));

  assert_rise_center_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && edge_found[1:0] == 2'b11) |-> (tap >= rise_lo_tap && tap <= rise_hi_tap));
endmodule

bind wdqs_center_cal wdqs_center_cal_chk #(.TW(TW)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .lim_req(lim_req), .lim_done(lim_done),
  .done(done), .tap(tap), .edge_found(edge_found),
  .rise_lo_tap(rise_lo_tap), .rise_hi_tap(rise_hi_tap),
  .fall_lo_tap(fall_lo_tap), .fall_hi_tap(fall_hi_tap)
);

// File: tb/test_wdqs_center_cal.sv
`timescale 1ns/1ps
module test_wdqs_center_cal;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] init_sel = '0;
  logic [3:0] settle_cycles = '0;
  logic       lim_req;
  logic       lim_done = 1'b0;
  logic [5:0] lim_left = '0, lim_right = '0;
  logic [1:0] sample_class = 2'b11;
  logic [5:0] tap;
  logic       done;
  logic [3:0] edge_found;
  logic [5:0] rise_lo_tap, rise_hi_tap, fall_lo_tap, fall_hi_tap;

  always #4 clk = ~clk;

  wdqs_center_cal i_wdqs_center_cal (
    .clk(clk), .rst_n(rst_n), .start(start), .init_sel(init_sel),
    .settle_cycles(settle_cycles), .lim_req(lim_req), .lim_done(lim_done),
    .lim_left(lim_left), .lim_right(lim_right), .sample_class(sample_class),
    .tap(tap), .done(done), .edge_found(edge_found),
    .rise_lo_tap(rise_lo_tap), .rise_hi_tap(rise_hi_tap),
    .fall_lo_tap(fall_lo_tap), .fall_hi_tap(fall_hi_tap)
  );

  int errors = 0;
  int checks = 0;
  int rlo, rhi, flo, fhi;
  int stab = 0;
  logic [5:0] ptap = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cls(input int t);
    if (t >= rlo && t <= rhi) return 1;
    if (t >= flo && t <= fhi) return 2;
    return 0;
  endfunction

  // delay-line model: class is garbage (11) until the tap has been steady settle_cycles cycles
  always @(negedge clk) begin
    if (tap == ptap) begin
      if (stab < 1000) stab = stab + 1;
    end else stab = 0;
    ptap = tap;
    sample_class = (stab >= int'(settle_cycles)) ? 2'(cls(int'(tap))) : 2'b11;
  end

  int ef[4];
  int et[4];

  task automatic rec(input int lo, input int a, input int b);
    if (b == 1 && a != 1) begin ef[0] = 1; et[0] = lo + 1; end
    if (a == 1 && b != 1) begin ef[1] = 1; et[1] = lo;     end
    if (b == 2 && a != 2) begin ef[2] = 1; et[2] = lo + 1; end
    if (a == 2 && b != 2) begin ef[3] = 1; et[3] = lo;     end
  endtask

  task automatic run_case(input int sel, input int st, input int scen);
    int i, L, R, t, p, c, dmin, umax, fin, l, r, n, mn, mx, eflags;
    bit srise;
    string rq;
    i = (sel > 6) ? 34 : 28 + sel;
    L = i - 10; R = i + 10;
    rlo = 99; rhi = 0; flo = 99; fhi = 0;
    case (scen)
      0: begin rlo = i - 5; rhi = i + 6; end
      1: begin rlo = 0; rhi = i + 4; L = i - 20; end
      2: begin rlo = i - 3; rhi = 63; end
      3: ;
      4: begin flo = i - 4; fhi = i + 3; end
      5: begin flo = i - 6; fhi = i - 1; rlo = i; rhi = i + 5; end
      6: begin rlo = i + 3; rhi = i + 9; end
      7: begin rlo = i - 5; rhi = i + 1; L = i; R = i + 2; end
      8: begin rlo = i - 2; rhi = 63; R = 63; end
      default: begin flo = i - 1; fhi = 50; end
    endcase
    for (int k = 0; k < 4; k++) begin ef[k] = 0; et[k] = 0; end
    t = i; p = cls(t);
    while (!(t <= L || t == 0)) begin
      t--; c = cls(t);
      if (c != p) begin rec(t, c, p); break; end
      p = c;
    end
    dmin = t;
    t = i; p = cls(t);
    while (!(t >= R || t == 63)) begin
      t++; c = cls(t);
      if (c != p) begin rec(t - 1, p, c); break; end
      p = c;
    end
    umax = t;
    srise = (ef[0] | ef[1]) != 0;
    l = srise ? et[0] : et[2];
    r = srise ? (ef[1] ? et[1] : 63) : (ef[3] ? et[3] : 63);
    fin = (ef[0] | ef[1] | ef[2] | ef[3]) ? (l + r) / 2 : i;
    eflags = ef[0] + 2 * ef[1] + 4 * ef[2] + 8 * ef[3];
    rq = (st != 0) ? "R8" : "R7";

    init_sel = 3'(sel); settle_cycles = 4'(st);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(tap == 6'(i), "R1 initial tap", int'(tap), i);
    chk(lim_req == 1'b1, "R1 lim_req raised", int'(lim_req), 1);
    chk(edge_found == 4'b0 && rise_lo_tap == 0 && fall_hi_tap == 0, "R11 flags cleared",
        int'(edge_found), 0);
    repeat (2) @(negedge clk);
    chk(lim_req == 1'b1, "R2 lim_req held", int'(lim_req), 1);
    lim_left = 6'(L); lim_right = 6'(R); lim_done = 1'b1;
    @(negedge clk); lim_done = 1'b0; lim_left = '0; lim_right = '0;
    chk(lim_req == 1'b0, "R2 lim_req dropped", int'(lim_req), 0);
    mn = i; mx = i; n = 0;
    while (!done && n < 5000) begin
      if (int'(tap) < mn) mn = int'(tap);
      if (int'(tap) > mx) mx = int'(tap);
      @(negedge clk); n++;
    end
    chk(done == 1'b1, "R9 done seen", int'(done), 1);
    chk(tap == 6'(fin), {rq, " final tap"}, int'(tap), fin);
    chk(edge_found == 4'(eflags), "R5 edge flags", int'(edge_found), eflags);
    chk(rise_lo_tap == 6'(et[0]), "R5 rise_lo_tap", int'(rise_lo_tap), et[0]);
    chk(rise_hi_tap == 6'(et[1]), "R5 rise_hi_tap", int'(rise_hi_tap), et[1]);
    chk(fall_lo_tap == 6'(et[2]), "R6 fall_lo_tap", int'(fall_lo_tap), et[2]);
    chk(fall_hi_tap == 6'(et[3]), "R6 fall_hi_tap", int'(fall_hi_tap), et[3]);
    chk(mn == dmin, "R3 down-leg stop tap", mn, dmin);
    chk(mx == umax, "R4 up-leg stop tap", mx, umax);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
    chk(tap == 6'(fin), "R9 tap holds", int'(tap), fin);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tap == 6'd0, "R10 reset tap", int'(tap), 0);
    chk(done == 1'b0 && lim_req == 1'b0, "R10 reset outputs", int'({done, lim_req}), 0);
    chk(edge_found == 4'b0 && rise_hi_tap == 0 && fall_lo_tap == 0, "R10 reset flags",
        int'(edge_found), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int st = 0; st <= 3; st += 3)
      for (int sel = 0; sel < 8; sel++)
        for (int scen = 0; scen < 10; scen++)
          run_case(sel, st, scen);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule